// File: doc/BRIEF.md
# Delayed Write Parity Responder

This block is the target-side control for one delayed write on a bridge that uses PCI-style active-low handshakes. It watches the initiator bus, captures the address phase and the first data phase of a write, checks even parity on both, and then answers with either a retry (the write is handed to a one-entry delayed-write store through a queue strobe) or, when a data parity error is seen and error response is enabled on the initiator side, an immediate accept with a parity error report two clocks later and nothing queued.

While an entry is held, a retried repeat of the write is compared against it on address, command, byte enables and data. A matching repeat raises a hit strobe. A repeat that does not match is retried and not stored. The entry is freed when the far side signals that the completion is done. A parity error reported by the far-side target during that completion is latched so it can be forwarded back toward the initiator. Three sticky status bits record the parity events and are cleared by a write-one-to-clear strobe.

Top module: `dwr_par_guard`

## Requirements
- R1: After synchronous reset, trdy_n, stop_n, devsel_n and perr_n are high, q_wr and q_hit are low and stat is 0.
- R2: A write begins when frame_n is sampled low in idle (ad = address, cbe_n = command). PAR in the next clock covers the address phase. The data phase is the first clock with irdy_n low; PAR in the clock after it covers the data. The response starts in the clock after that data-parity clock and holds until frame_n and irdy_n are both sampled high. In every response devsel_n is low.
- R3: Parity is even: an error exists when PAR differs from the XOR of all 32 ad bits and all 4 cbe_n bits of the phase it covers.
- R4: With good data parity the response is a retry (stop_n low, trdy_n high). If no entry is held, q_wr pulses for the first response clock only, with q_addr, q_cmd, q_apar, q_data, q_be_n and q_dpar equal to the captured address, command, address-phase PAR, data, byte enables and data-phase PAR.
- R5: With a data parity error and resp_en_near high, trdy_n is low for the whole response, nothing is queued and q_hit stays low. stop_n stays high if frame_n was high in the data phase.
- R6: In that accept case, if frame_n was still low in the data phase (more phases requested), stop_n is low together with trdy_n.
- R7: After an accept, perr_n is low for exactly one clock, the second clock after the first response clock.
- R8: With a data parity error and resp_en_near low, the response is the normal retry, the write is queued as in R4, and perr_n stays high.
- R9: stat bit 0 is set on every data parity error whatever resp_en_near is. All stat bits are sticky; a 1 in stat_clr clears the matching bit, and a set in the same clock wins over the clear.
- R10: A far_perr pulse always sets stat bit 2, and sets stat bit 1 only when resp_en_far is high.
- R11: While an entry is held, a retried write whose address, command, byte enables and data all match it pulses q_hit in the first response clock; any difference gives no q_hit. In both cases q_wr stays low and the held entry is kept.
- R12: A far_done pulse frees the entry, so the next retried write is queued again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Initiator frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad | input | 32 | Multiplexed address/data |
| cbe_n | input | 4 | Command / byte enables, active low |
| par | input | 1 | Even parity for the previous phase |
| resp_en_near | input | 1 | Parity error response enable, initiator side |
| resp_en_far | input | 1 | Parity error response enable, far side |
| far_perr | input | 1 | Far-side target reported a parity error (pulse) |
| far_done | input | 1 | Far-side completion finished, frees the entry (pulse) |
| stat_clr | input | 3 | Write-one-to-clear strobes for stat |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target stop, active low |
| devsel_n | output | 1 | Device select, active low |
| perr_n | output | 1 | Data parity error report, active low |
| q_wr | output | 1 | Queue write strobe |
| q_hit | output | 1 | Repeat matched held entry (pulse) |
| q_addr | output | 32 | Captured address |
| q_cmd | output | 4 | Captured command |
| q_apar | output | 1 | Captured address-phase PAR |
| q_data | output | 32 | Captured write data |
| q_be_n | output | 4 | Captured byte enables |
| q_dpar | output | 1 | Captured data-phase PAR |
| stat | output | 3 | Sticky status: 0 data parity detected, 1 far error with response enabled, 2 far error latched for forwarding |

## Verification
Writes are driven with good and bad data parity, each under both settings of resp_en_near, so the retry-and-queue path is told apart from the accept-and-report path and the status bit is seen to set in both. Single-phase and multi-phase writes separate the plain accept from the disconnect. Repeats that match the held entry, and repeats that differ only in data or only in command or address, show that the compare covers each field and that nothing is stored twice; a bad address parity is carried into q_apar. Far-side error pulses under both resp_en_far values and clears that collide with sets cover the status bits.

// File: rtl/dwr_pkg.sv
package dwr_pkg;
    localparam int DW     = 32;
    localparam int BW     = DW / 8;
    localparam int STAT_W = 3;
    localparam int ST_DET = 0;
    localparam int ST_FAR = 1;
    localparam int ST_FWD = 2;

    typedef enum logic [1:0] {PH_IDLE, PH_DATA, PH_CHK, PH_RESP} ph_t;

    typedef struct packed {
        logic [DW-1:0] addr;
        logic [BW-1:0] cmd;
        logic          apar;
        logic [DW-1:0] data;
        logic [BW-1:0] be_n;
        logic          dpar;
    } dw_req_t;

    function automatic logic even_par(input logic [DW-1:0] d, input logic [BW-1:0] c);
        return ^{d, c};
    endfunction
endpackage

// File: rtl/dwr_phase.sv
module dwr_phase
    import dwr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_n,
    input  logic          irdy_n,
    input  logic [DW-1:0] ad,
    input  logic [BW-1:0] cbe_n,
    input  logic          par,
    output dw_req_t       req,
    output logic          multi,
    output logic          dperr,
    output logic          in_resp,
    output logic          resp_first,
    output logic          dp_bad_now
);
    ph_t  state;
    logic apar_pend;
    logic first;

    assign dp_bad_now = (state == PH_CHK) && (par != even_par(req.data, req.be_n));
    assign in_resp    = (state == PH_RESP);
    assign resp_first = in_resp && first;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PH_IDLE;
            req       <= '0;
            apar_pend <= 1'b0;
            multi     <= 1'b0;
            dperr     <= 1'b0;
            first     <= 1'b0;
        end else begin
            unique case (state)
                PH_IDLE: begin
                    if (!frame_n) begin
                        req.addr  <= ad;
                        req.cmd   <= cbe_n;
                        apar_pend <= 1'b1;
                        state     <= PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (apar_pend) begin
                        req.apar  <= par;
                        apar_pend <= 1'b0;
                    end
                    if (!irdy_n) begin
                        req.data <= ad;
                        req.be_n <= cbe_n;
                        multi    <= !frame_n;
                        state    <= PH_CHK;
                    end
                end
                PH_CHK: begin
                    req.dpar <= par;
                    dperr    <= dp_bad_now;
                    first    <= 1'b1;
                    state    <= PH_RESP;
                end
                PH_RESP: begin
                    first <= 1'b0;
                    if (frame_n && irdy_n) state <= PH_IDLE;
                end
                default: state <= PH_IDLE;
            endcase
        end
    end

    // R2: the response opens only after the data-parity clock
    a_r2_resp_after_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(in_resp) |-> $past(state) == PH_CHK);
endmodule

// File: rtl/dwr_entry.sv
module dwr_entry
    import dwr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          offer,
    input  logic          free,
    input  logic [DW-1:0] key_addr,
    input  logic [BW-1:0] key_cmd,
    input  logic [BW-1:0] key_be_n,
    input  logic [DW-1:0] key_data,
    output logic          q_wr,
    output logic          q_hit
);
    logic          valid;
    logic [DW-1:0] e_addr;
    logic [BW-1:0] e_cmd;
    logic [BW-1:0] e_be_n;
    logic [DW-1:0] e_data;
    logic          match;

    assign match = (e_addr == key_addr) && (e_cmd == key_cmd) &&
                   (e_be_n == key_be_n) && (e_data == key_data);
    assign q_wr  = offer && !valid;
    assign q_hit = offer && valid && match;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= 1'b0;
            e_addr <= '0;
            e_cmd  <= '0;
            e_be_n <= '0;
            e_data <= '0;
        end else if (q_wr) begin
            valid  <= 1'b1;
            e_addr <= key_addr;
            e_cmd  <= key_cmd;
            e_be_n <= key_be_n;
            e_data <= key_data;
        end else if (free) begin
            valid <= 1'b0;
        end
    end

    // R11: once stored, the entry is not stored again next clock
    a_r11_single_store: assert property (@(posedge clk) disable iff (rst)
        q_wr |=> (valid && !q_wr));
    // R12: a free with no store empties the entry
    a_r12_free_clears: assert property (@(posedge clk) disable iff (rst)
        (free && !q_wr) |=> !valid);
endmodule

// File: rtl/dwr_status.sv
module dwr_status
    import dwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dp_bad,
    input  logic              xfer_bad,
    input  logic              far_perr,
    input  logic              resp_en_far,
    input  logic [STAT_W-1:0] clr,
    output logic [STAT_W-1:0] stat,
    output logic              perr_n
);
    logic [STAT_W-1:0] set;
    logic              p1;

    always_comb begin
        set         = '0;
        set[ST_DET] = dp_bad;
        set[ST_FAR] = far_perr && resp_en_far;
        set[ST_FWD] = far_perr;
    end

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) stat[i] <= 1'b0;
            else     stat[i] <= (stat[i] && !clr[i]) || set[i];
        end
        // R9: a set bit survives any clock without its clear strobe
        a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
            (stat[i] && !clr[i]) |=> stat[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p1     <= 1'b0;
            perr_n <= 1'b1;
        end else begin
            p1     <= xfer_bad;
            perr_n <= !p1;
        end
    end

    // R7: report lags the bad transfer by two clocks and lasts one
    a_r7_perr_lag: assert property (@(posedge clk) disable iff (rst)
        !perr_n |-> $past(xfer_bad, 2));
    a_r7_perr_pulse: assert property (@(posedge clk) disable iff (rst)
        !perr_n |=> perr_n);
endmodule

// File: rtl/dwr_par_guard.sv
module dwr_par_guard
    import dwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic [DW-1:0]     ad,
    input  logic [BW-1:0]     cbe_n,
    input  logic              par,
    input  logic              resp_en_near,
    input  logic              resp_en_far,
    input  logic              far_perr,
    input  logic              far_done,
    input  logic [STAT_W-1:0] stat_clr,
    output logic              trdy_n,
    output logic              stop_n,
    output logic              devsel_n,
    output logic              perr_n,
    output logic              q_wr,
    output logic              q_hit,
    output logic [DW-1:0]     q_addr,
    output logic [BW-1:0]     q_cmd,
    output logic              q_apar,
    output logic [DW-1:0]     q_data,
    output logic [BW-1:0]     q_be_n,
    output logic              q_dpar,
    output logic [STAT_W-1:0] stat
);
    dw_req_t req;
    logic    multi, dperr, in_resp, resp_first, dp_bad_now;
    logic    accept, offer, xfer_bad;

    dwr_phase u_phase (
        .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n),
        .ad(ad), .cbe_n(cbe_n), .par(par), .req(req), .multi(multi),
        .dperr(dperr), .in_resp(in_resp), .resp_first(resp_first),
        .dp_bad_now(dp_bad_now)
    );

    assign accept   = dperr && resp_en_near;
    assign offer    = resp_first && !accept;
    assign xfer_bad = resp_first && accept && !irdy_n;

    assign devsel_n = !in_resp;
    assign trdy_n   = !(in_resp && accept);
    assign stop_n   = !(in_resp && (!accept || multi));

    dwr_entry u_entry (
        .clk(clk), .rst(rst), .offer(offer), .free(far_done),
        .key_addr(req.addr), .key_cmd(req.cmd), .key_be_n(req.be_n),
        .key_data(req.data), .q_wr(q_wr), .q_hit(q_hit)
    );

    dwr_status u_status (
        .clk(clk), .rst(rst), .dp_bad(dp_bad_now), .xfer_bad(xfer_bad),
        .far_perr(far_perr), .resp_en_far(resp_en_far), .clr(stat_clr),
        .stat(stat), .perr_n(perr_n)
    );

    assign q_addr = req.addr;
    assign q_cmd  = req.cmd;
    assign q_apar = req.apar;
    assign q_data = req.data;
    assign q_be_n = req.be_n;
    assign q_dpar = req.dpar;

    // R4: a queue strobe only ever rides on a retry response
    a_r4_queue_on_retry: assert property (@(posedge clk) disable iff (rst)
        q_wr |-> (!devsel_n && !stop_n && trdy_n));
    // R8: with near response off the data phase is never accepted
    a_r8_no_accept_off: assert property (@(posedge clk) disable iff (rst)
        (!devsel_n && !resp_en_near) |-> trdy_n);
    // R6: an accepted multi-phase write is disconnected
    a_r6_disconnect: assert property (@(posedge clk) disable iff (rst)
        (!trdy_n && multi) |-> !stop_n);
endmodule

// File: tb/dwr_par_guard_bench.sv
module dwr_par_guard_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1, irdy_n = 1'b1, par = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = '1;
    logic        resp_en_near = 1'b0, resp_en_far = 1'b0, far_perr = 1'b0, far_done = 1'b0;
    logic [2:0]  stat_clr = '0;
    logic        trdy_n, stop_n, devsel_n, perr_n, q_wr, q_hit, q_apar, q_dpar;
    logic [31:0] q_addr, q_data;
    logic [3:0]  q_cmd, q_be_n;
    logic [2:0]  stat;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dwr_par_guard u_dwr_par_guard (
        .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .ad(ad),
        .cbe_n(cbe_n), .par(par), .resp_en_near(resp_en_near),
        .resp_en_far(resp_en_far), .far_perr(far_perr), .far_done(far_done),
        .stat_clr(stat_clr), .trdy_n(trdy_n), .stop_n(stop_n),
        .devsel_n(devsel_n), .perr_n(perr_n), .q_wr(q_wr), .q_hit(q_hit),
        .q_addr(q_addr), .q_cmd(q_cmd), .q_apar(q_apar), .q_data(q_data),
        .q_be_n(q_be_n), .q_dpar(q_dpar), .stat(stat)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [3:0]  cmd;
        logic [31:0] data;
        logic [3:0]  be_n;
        logic        abad;
        logic        dbad;
        logic        multi;
        logic        near;
        logic        free;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 4'h7, 32'hDEAD_BEEF, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{32'h0000_1000, 4'h7, 32'hDEAD_BEEF, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{32'h0000_2000, 4'h7, 32'h1234_5678, 4'h3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        '{32'h0000_2000, 4'h7, 32'h1234_5678, 4'h3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        '{32'h0000_3000, 4'h7, 32'h0F0F_0F0F, 4'h0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        '{32'h0000_4000, 4'h7, 32'hA5A5_0001, 4'h1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{32'h0000_4000, 4'h7, 32'hA5A5_0001, 4'h1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{32'h0000_4000, 4'h7, 32'hA5A5_0002, 4'h1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{32'h0000_5000, 4'hF, 32'hFFFF_FFFF, 4'hF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{32'h0000_5000, 4'hB, 32'hFFFF_FFFF, 4'hF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    // bench model of the held entry
    logic        m_valid = 1'b0;
    logic [31:0] m_addr = '0, m_data = '0;
    logic [3:0]  m_cmd = '0, m_be = '0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        logic acc, qwr, hit, apar, dpar;
        acc  = v.dbad && v.near;
        hit  = !acc && m_valid && (m_addr == v.addr) && (m_cmd == v.cmd) &&
               (m_be == v.be_n) && (m_data == v.data);
        apar = (^{v.addr, v.cmd}) ^ v.abad;
        dpar = (^{v.data, v.be_n}) ^ v.dbad;
        if (v.free) m_valid = 1'b0;
        qwr  = !acc && !m_valid;
        // clear status, optionally free the entry
        @(negedge clk); stat_clr = 3'b111; far_done = v.free; resp_en_near = v.near;
        @(negedge clk); stat_clr = 3'b000; far_done = 1'b0;
        chk("R9 clear", 64'(stat), 64'd0);
        // address phase
        frame_n = 1'b0; irdy_n = 1'b1; ad = v.addr; cbe_n = v.cmd;
        @(negedge clk);
        ad = v.data; cbe_n = v.be_n; irdy_n = 1'b0; frame_n = !v.multi; par = apar;
        @(negedge clk);
        par = dpar;
        @(negedge clk);
        // first response clock
        chk("R2 devsel", 64'(devsel_n), 64'd0);
        chk(acc ? "R5 trdy" : "R4 trdy", 64'(trdy_n), 64'(!acc));
        chk(acc ? "R6 stop" : "R4 stop", 64'(stop_n), 64'(acc && !v.multi));
        chk(v.dbad && !v.near ? "R8 q_wr" : "R4 q_wr", 64'(q_wr), 64'(qwr));
        chk("R11 q_hit", 64'(q_hit), 64'(hit));
        chk("R3 R9 det", 64'(stat[0]), 64'(v.dbad));
        if (qwr) begin
            chk("R4 q_addr", 64'(q_addr), 64'(v.addr));
            chk("R4 q_cmd", 64'(q_cmd), 64'(v.cmd));
            chk("R4 q_apar", 64'(q_apar), 64'(apar));
            chk("R4 q_data", 64'(q_data), 64'(v.data));
            chk("R4 q_be_n", 64'(q_be_n), 64'(v.be_n));
            chk("R4 q_dpar", 64'(q_dpar), 64'(dpar));
            m_valid = 1'b1; m_addr = v.addr; m_cmd = v.cmd; m_be = v.be_n; m_data = v.data;
        end
        @(negedge clk);
        chk("R4 q_wr pulse", 64'(q_wr), 64'd0);
        chk("R7 perr early", 64'(perr_n), 64'd1);
        frame_n = 1'b1; irdy_n = 1'b1;
        @(negedge clk);
        chk(v.dbad && !v.near ? "R8 perr" : "R7 perr", 64'(perr_n), 64'(!acc));
        chk("R2 release", 64'(devsel_n), 64'd1);
        @(negedge clk);
        chk("R7 perr one clock", 64'(perr_n), 64'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 trdy", 64'(trdy_n), 64'd1);
        chk("R1 stop", 64'(stop_n), 64'd1);
        chk("R1 devsel", 64'(devsel_n), 64'd1);
        chk("R1 perr", 64'(perr_n), 64'd1);
        chk("R1 q_wr", 64'({q_wr, q_hit}), 64'd0);
        chk("R1 stat", 64'(stat), 64'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R10: far error, far response disabled
        @(negedge clk); far_perr = 1'b1; resp_en_far = 1'b0;
        @(negedge clk); far_perr = 1'b0;
        chk("R10 far off", 64'(stat), 64'b100);
        // R10: far error, far response enabled
        far_perr = 1'b1; resp_en_far = 1'b1;
        @(negedge clk); far_perr = 1'b0;
        chk("R10 far on", 64'(stat), 64'b110);
        // R9: clear one bit only
        stat_clr = 3'b100;
        @(negedge clk); stat_clr = 3'b000;
        chk("R9 partial clear", 64'(stat), 64'b010);
        // R9: set beats clear in the same clock
        far_perr = 1'b1; resp_en_far = 1'b0; stat_clr = 3'b110;
        @(negedge clk); far_perr = 1'b0; stat_clr = 3'b000;
        chk("R9 set wins", 64'(stat), 64'b100);
        @(negedge clk);
        chk("R9 held", 64'(stat), 64'b100);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule